// File: doc/BRIEF.md
# Streaming Parallel CRC Engine

This block computes a cyclic redundancy check over a stream of data words, folding one complete word into the CRC register on each clock in which the word is qualified as valid. The polynomial, CRC width, word width, starting value, input and output bit reflection and the final XOR mask are fixed when the block is elaborated. The word update is a fixed XOR network whose taps are derived from those parameters at elaboration time, so any CRC width and any word width from 1 to 64 bits can be built, byte multiples or not.

A start-of-message flag travels with the data. When it is high on a valid word, the computation restarts from the initial value and that same word is already part of the new message, so consecutive messages can follow each other with no idle cycle between them. When it is high with no valid word, the register is simply reloaded with the initial value and the data bus is ignored. The output shows the formatted CRC of every word accepted so far, and a match flag goes high when the register holds the residue left after a message followed by its own correct CRC.

There is no state machine: the only state is the CRC register itself, which has three moves per cycle (hold, restart-and-fold, fold) plus a reload.

Top module: `crc_stream`

## Requirements
- R1: After reset the CRC register holds the initial value INIT_CRC, so crc_o equals INIT_CRC after output formatting (R6).
- R2: With in_valid low and in_first low the register holds; crc_o and match_o do not change whatever in_data carries.
- R3: With in_valid high and in_first low the word is folded into the register exactly as a bit-serial CRC shift register would absorb it, most significant data bit first; with REFL_IN set the word is bit-reversed first, so its least significant bit enters first.
- R4: With in_valid high and in_first high the fold starts from INIT_CRC instead of the register contents, and the word on in_data is included in the result.
- R5: With in_first high and in_valid low the register is loaded with INIT_CRC and in_data is ignored.
- R6: crc_o equals the register, bit-reversed across CRC_W bits when REFL_OUT is set, XORed with XOR_OUT; it changes in the cycle after the clock edge that accepted a word.
- R7: match_o is high exactly when the register equals the residue obtained by serially shifting the CRC_W-bit value (REFL_OUT ? reversed XOR_OUT : XOR_OUT), most significant bit first, into an all-zero register; appending a message's CRC in stream bit order therefore raises match_o.
- R8: Word width and CRC width are independent; a 12-bit word with an 8-bit CRC gives the same result as the bit-serial model.
- R9: A message may start with in_first on the word right after the last word of the previous message, with no idle cycle, and its CRC is unaffected by the previous message.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; loads INIT_CRC |
| in_data | input | DATA_W | Data word |
| in_valid | input | 1 | Word on in_data is to be absorbed this cycle |
| in_first | input | 1 | Start of message: restart from INIT_CRC |
| crc_o | output | CRC_W | Formatted CRC of all words accepted so far |
| match_o | output | 1 | Register equals the good-message residue |

## Verification
The embedded properties watch, on every cycle, that an idle cycle leaves both outputs unchanged, that a reload without a valid word puts the formatted initial value and its matching match flag on the outputs, and that reset lands on the initial value. Whether each folded word produces the right CRC, whether restart-with-data really discards the previous message, and whether the residue flag rises after a correct appended CRC can only be shown by the bench scenarios, which compare the engine against an independent bit-serial model for 32-bit, 16-bit and 8-bit CRCs, including a 12-bit word width and back-to-back messages.

// File: rtl/crc_stream_pkg.sv
package crc_stream_pkg;

    typedef logic [63:0] wide_t;

    function automatic wide_t low_mask(input int w);
        if (w >= 64) return '1;
        return (64'd1 << w) - 64'd1;
    endfunction

    function automatic wide_t bit_rev(input wide_t v, input int w);
        wide_t r;
        r = '0;
        for (int i = 0; i < w; i++) r[i] = v[w-1-i];
        return r;
    endfunction

    // Bit-serial shift of dw data bits (MSB first) into a cw-bit register.
    function automatic wide_t serial_fold(input wide_t st, input wide_t dat,
                                          input int cw, input int dw,
                                          input wide_t poly);
        wide_t r;
        logic  fb;
        r = st & low_mask(cw);
        for (int k = dw - 1; k >= 0; k--) begin
            fb = r[cw-1] ^ dat[k];
            r  = (r << 1) & low_mask(cw);
            if (fb) r = r ^ (poly & low_mask(cw));
        end
        return r;
    endfunction

    // Column of the update matrix: which state bits feed output bit o.
    function automatic wide_t state_taps(input int o, input int cw, input int dw,
                                         input wide_t poly);
        wide_t m;
        wide_t col;
        m = '0;
        for (int j = 0; j < cw; j++) begin
            col  = serial_fold(64'd1 << j, '0, cw, dw, poly);
            m[j] = col[o];
        end
        return m;
    endfunction

    // Which data bits feed output bit o.
    function automatic wide_t data_taps(input int o, input int cw, input int dw,
                                        input wide_t poly);
        wide_t m;
        wide_t col;
        m = '0;
        for (int j = 0; j < dw; j++) begin
            col  = serial_fold('0, 64'd1 << j, cw, dw, poly);
            m[j] = col[o];
        end
        return m;
    endfunction

    function automatic wide_t good_residue(input int cw, input wide_t poly,
                                           input wide_t xor_out, input bit refl_out);
        wide_t pat;
        pat = refl_out ? bit_rev(xor_out, cw) : (xor_out & low_mask(cw));
        return serial_fold('0, pat, cw, cw, poly);
    endfunction

endpackage

// File: rtl/crc_matrix.sv
module crc_matrix
    import crc_stream_pkg::*;
#(
    parameter int    CRC_W  = 32,
    parameter int    DATA_W = 8,
    parameter wide_t POLY   = 64'h04C11DB7
) (
    input  logic [CRC_W-1:0]  st_i,
    input  logic [DATA_W-1:0] dat_i,
    output logic [CRC_W-1:0]  nxt_o
);

    for (genvar i = 0; i < CRC_W; i++) begin : g_bit
        localparam wide_t SM = state_taps(i, CRC_W, DATA_W, POLY);
        localparam wide_t DM = data_taps(i, CRC_W, DATA_W, POLY);
        logic [CRC_W-1:0]  st_sel;
        logic [DATA_W-1:0] dat_sel;
        assign st_sel   = st_i  & SM[CRC_W-1:0];
        assign dat_sel  = dat_i & DM[DATA_W-1:0];
        assign nxt_o[i] = (^st_sel) ^ (^dat_sel);
    end

endmodule

// File: rtl/crc_outfmt.sv
module crc_outfmt
    import crc_stream_pkg::*;
#(
    parameter int    CRC_W    = 32,
    parameter bit    REFL_OUT = 1'b1,
    parameter wide_t XOR_OUT  = 64'hFFFFFFFF,
    parameter wide_t RESID    = 64'h0
) (
    input  logic [CRC_W-1:0] raw_i,
    output logic [CRC_W-1:0] crc_o,
    output logic             match_o
);

    logic [CRC_W-1:0] ordered;

    if (REFL_OUT) begin : g_rev
        for (genvar i = 0; i < CRC_W; i++) begin : g_b
            assign ordered[i] = raw_i[CRC_W-1-i];
        end
    end else begin : g_keep
        assign ordered = raw_i;
    end

    assign crc_o   = ordered ^ XOR_OUT[CRC_W-1:0];
    assign match_o = (raw_i == RESID[CRC_W-1:0]);

endmodule

// File: rtl/crc_stream.sv
module crc_stream
    import crc_stream_pkg::*;
#(
    parameter int    CRC_W    = 32,
    parameter int    DATA_W   = 8,
    parameter wide_t POLY     = 64'h04C11DB7,
    parameter wide_t INIT_CRC = 64'hFFFFFFFF,
    parameter bit    REFL_IN  = 1'b1,
    parameter bit    REFL_OUT = 1'b1,
    parameter wide_t XOR_OUT  = 64'hFFFFFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_valid,
    input  logic              in_first,
    output logic [CRC_W-1:0]  crc_o,
    output logic              match_o
);

    localparam logic [CRC_W-1:0] INIT_V = INIT_CRC[CRC_W-1:0];
    localparam wide_t RESID    = good_residue(CRC_W, POLY, XOR_OUT, REFL_OUT);
    localparam wide_t INIT_FMT_W =
        ((REFL_OUT ? bit_rev(INIT_CRC, CRC_W) : INIT_CRC) ^ XOR_OUT) & low_mask(CRC_W);
    localparam logic [CRC_W-1:0] INIT_FMT = INIT_FMT_W[CRC_W-1:0];
    localparam logic INIT_MATCH = (INIT_V == RESID[CRC_W-1:0]);

    logic [CRC_W-1:0]  state_q;
    logic [CRC_W-1:0]  state_d;
    logic [CRC_W-1:0]  start_st;
    logic [CRC_W-1:0]  folded;
    logic [DATA_W-1:0] fed;

    if (REFL_IN) begin : g_in_rev
        for (genvar i = 0; i < DATA_W; i++) begin : g_b
            assign fed[i] = in_data[DATA_W-1-i];
        end
    end else begin : g_in_keep
        assign fed = in_data;
    end

    // Start-of-message muxes the starting state ahead of the update network.
    assign start_st = in_first ? INIT_V : state_q;

    crc_matrix #(
        .CRC_W (CRC_W),
        .DATA_W(DATA_W),
        .POLY  (POLY)
    ) u_matrix (
        .st_i (start_st),
        .dat_i(fed),
        .nxt_o(folded)
    );

    always_comb begin
        if (in_valid)      state_d = folded;
        else if (in_first) state_d = INIT_V;
        else               state_d = state_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= INIT_V;
        else        state_q <= state_d;
    end

    crc_outfmt #(
        .CRC_W   (CRC_W),
        .REFL_OUT(REFL_OUT),
        .XOR_OUT (XOR_OUT),
        .RESID   (RESID)
    ) u_fmt (
        .raw_i  (state_q),
        .crc_o  (crc_o),
        .match_o(match_o)
    );

    p_reset_init_r1: assert property (@(posedge clk)
        !rst_n |=> (crc_o == INIT_FMT));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid && !in_first) |=> ($stable(crc_o) && $stable(match_o)));

    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_first && !in_valid) |=> (crc_o == INIT_FMT));

    p_reload_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_first && !in_valid) |=> (match_o == INIT_MATCH));

endmodule

// File: tb/crc_stream_test.sv
module crc_stream_test;

    localparam int CLK_NS = 10;

    localparam int          CW [3] = '{32, 16, 8};
    localparam int          DW [3] = '{8, 16, 12};
    localparam logic [63:0] PL [3] = '{64'h04C11DB7, 64'h1021, 64'h07};
    localparam logic [63:0] IV [3] = '{64'hFFFFFFFF, 64'hFFFF, 64'h00};
    localparam bit          RI [3] = '{1'b1, 1'b0, 1'b1};
    localparam bit          RO [3] = '{1'b1, 1'b0, 1'b0};
    localparam logic [63:0] XO [3] = '{64'hFFFFFFFF, 64'h0, 64'h55};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_NS / 2) clk = ~clk;

    logic [7:0]  d0 = '0;
    logic [15:0] d1 = '0;
    logic [11:0] d2 = '0;
    logic        v0 = 0, v1 = 0, v2 = 0, f0 = 0, f1 = 0, f2 = 0;
    logic [31:0] c0;
    logic [15:0] c1;
    logic [7:0]  c2;
    logic        m0, m1, m2;

    crc_stream #(.CRC_W(CW[0]), .DATA_W(DW[0]), .POLY(PL[0]), .INIT_CRC(IV[0]),
                 .REFL_IN(RI[0]), .REFL_OUT(RO[0]), .XOR_OUT(XO[0])) uut (
        .clk(clk), .rst_n(rst_n), .in_data(d0), .in_valid(v0), .in_first(f0),
        .crc_o(c0), .match_o(m0));

    crc_stream #(.CRC_W(CW[1]), .DATA_W(DW[1]), .POLY(PL[1]), .INIT_CRC(IV[1]),
                 .REFL_IN(RI[1]), .REFL_OUT(RO[1]), .XOR_OUT(XO[1])) uut_c16 (
        .clk(clk), .rst_n(rst_n), .in_data(d1), .in_valid(v1), .in_first(f1),
        .crc_o(c1), .match_o(m1));

    crc_stream #(.CRC_W(CW[2]), .DATA_W(DW[2]), .POLY(PL[2]), .INIT_CRC(IV[2]),
                 .REFL_IN(RI[2]), .REFL_OUT(RO[2]), .XOR_OUT(XO[2])) uut_c8 (
        .clk(clk), .rst_n(rst_n), .in_data(d2), .in_valid(v2), .in_first(f2),
        .crc_o(c2), .match_o(m2));

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        int          unit;
        logic [63:0] crc;
        logic        mt;
        string       tag;
    } exp_t;
    exp_t sbq[$];
    logic [63:0] ms [3];

    function automatic logic [63:0] msk(int w);
        return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    endfunction

    function automatic logic [63:0] flip(logic [63:0] v, int w);
        logic [63:0] r = '0;
        for (int i = 0; i < w; i++) r[i] = v[w-1-i];
        return r;
    endfunction

    // Left-shifting serial register, MSB of pattern first.
    function automatic logic [63:0] shl_feed(logic [63:0] st, logic [63:0] w, int nb,
                                             int cw, logic [63:0] p);
        logic [63:0] r = st;
        logic fb;
        for (int k = nb - 1; k >= 0; k--) begin
            fb = r[cw-1] ^ w[k];
            r  = (r << 1) & msk(cw);
            if (fb) r = r ^ p;
        end
        return r & msk(cw);
    endfunction

    // Reference: reflected inputs use a right-shifting register.
    function automatic logic [63:0] ref_fold(int u, logic [63:0] st, logic [63:0] w);
        logic [63:0] rs, rp;
        logic fb;
        if (RI[u]) begin
            rs = flip(st, CW[u]);
            rp = flip(PL[u], CW[u]);
            for (int k = 0; k < DW[u]; k++) begin
                fb = rs[0] ^ w[k];
                rs = rs >> 1;
                if (fb) rs = rs ^ rp;
            end
            return flip(rs, CW[u]);
        end
        return shl_feed(st, w, DW[u], CW[u], PL[u]);
    endfunction

    function automatic logic [63:0] ref_fmt(int u, logic [63:0] st);
        return ((RO[u] ? flip(st, CW[u]) : st) ^ XO[u]) & msk(CW[u]);
    endfunction

    function automatic logic [63:0] ref_resid(int u);
        logic [63:0] pat = RO[u] ? flip(XO[u], CW[u]) : XO[u];
        return shl_feed('0, pat, CW[u], CW[u], PL[u]);
    endfunction

    task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drv(int u, logic [63:0] d, bit v, bit f, string tag);
        exp_t e;
        @(negedge clk);
        case (u)
            0: begin d0 = d[7:0];  v0 = v; f0 = f; end
            1: begin d1 = d[15:0]; v1 = v; f1 = f; end
            default: begin d2 = d[11:0]; v2 = v; f2 = f; end
        endcase
        @(posedge clk);
        #1;
        if (v) ms[u] = ref_fold(u, f ? IV[u] : ms[u], d & msk(DW[u]));
        else if (f) ms[u] = IV[u];
        v0 = 0; v1 = 0; v2 = 0; f0 = 0; f1 = 0; f2 = 0;
        e.unit = u;
        e.crc  = ref_fmt(u, ms[u]);
        e.mt   = (ms[u] == ref_resid(u));
        e.tag  = tag;
        sbq.push_back(e);
    endtask

    // Monitor: compare each expected item once the edge has passed.
    always @(negedge clk) begin
        exp_t e;
        logic [63:0] ac;
        logic am;
        if (sbq.size() != 0) begin
            e = sbq.pop_front();
            case (e.unit)
                0: begin ac = {32'd0, c0}; am = m0; end
                1: begin ac = {48'd0, c1}; am = m1; end
                default: begin ac = {56'd0, c2}; am = m2; end
            endcase
            chk(ac == e.crc, {e.tag, " crc"}, ac, e.crc);
            chk(am == e.mt, {e.tag, " match"}, {63'd0, am}, {63'd0, e.mt});
        end
    end

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    initial begin
        #(CLK_NS * 100000);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] lcg;
        logic [15:0] c16v;
        for (int u = 0; u < 3; u++) ms[u] = IV[u];
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state, formatted
        chk(c0 == 32'h00000000, "R1 crc32 reset", {32'd0, c0}, 64'h0);
        chk(c1 == 16'hFFFF, "R1 crc16 reset", {48'd0, c1}, 64'hFFFF);
        chk(c2 == 8'h55, "R1 crc8 reset", {56'd0, c2}, 64'h55);
        rst_n = 1'b1;

        // R3/R4: ASCII 1..9 on the 32-bit reflected engine, first on word 0
        for (int i = 0; i < 9; i++)
            drv(0, 64'h31 + i, 1'b1, i == 0, "R3 crc32 digits");
        settle();
        chk(c0 == 32'hCBF43926, "R3 crc32 check value", {32'd0, c0}, 64'hCBF43926);

        // R2: garbage with no qualifier
        drv(0, 64'hA5, 1'b0, 1'b0, "R2 idle garbage");
        drv(0, 64'h5A, 1'b0, 1'b0, "R2 idle garbage");
        settle();
        chk(c0 == 32'hCBF43926, "R2 crc32 held", {32'd0, c0}, 64'hCBF43926);

        // R7: append CRC bytes, least significant first
        drv(0, 64'h26, 1'b1, 1'b0, "R7 append");
        drv(0, 64'h39, 1'b1, 1'b0, "R7 append");
        drv(0, 64'hF4, 1'b1, 1'b0, "R7 append");
        drv(0, 64'hCB, 1'b1, 1'b0, "R7 append");
        settle();
        chk(m0 == 1'b1, "R7 crc32 residue match", {63'd0, m0}, 64'd1);

        // R5: reload without valid ignores data
        drv(0, 64'h77, 1'b0, 1'b1, "R5 reload");
        settle();
        chk(c0 == 32'h0 && m0 == 1'b0, "R5 crc32 reload", {32'd0, c0}, 64'h0);

        // R4: restart mid-message equals fresh start
        drv(0, 64'h10, 1'b1, 1'b1, "R4 first");
        drv(0, 64'h20, 1'b1, 1'b0, "R4 body");
        drv(0, 64'h10, 1'b1, 1'b1, "R4 restart");
        settle();
        chk(c0 == ref_fmt(0, ref_fold(0, IV[0], 64'h10)), "R4 restart fresh",
            {32'd0, c0}, ref_fmt(0, ref_fold(0, IV[0], 64'h10)));

        // R9: back-to-back messages on 16-bit engine
        drv(1, 64'h3132, 1'b1, 1'b1, "R9 msgA");
        drv(1, 64'h3334, 1'b1, 1'b0, "R9 msgA");
        drv(1, 64'h3536, 1'b1, 1'b0, "R9 msgA");
        drv(1, 64'hBEEF, 1'b1, 1'b1, "R9 msgB first");
        drv(1, 64'h0102, 1'b1, 1'b0, "R9 msgB");
        settle();
        c16v = c1;
        chk(c16v == ref_fold(1, ref_fold(1, IV[1], 64'hBEEF), 64'h0102),
            "R9 msgB independent", {48'd0, c16v},
            ref_fold(1, ref_fold(1, IV[1], 64'hBEEF), 64'h0102));
        drv(1, {48'd0, c16v}, 1'b1, 1'b0, "R7 crc16 append");
        settle();
        chk(m1 == 1'b1 && c1 == 16'h0, "R7 crc16 residue match", {48'd0, c1}, 64'h0);

        // R8: 12-bit words, 8-bit CRC, mixed reflection
        lcg = 64'h1234;
        for (int i = 0; i < 20; i++) begin
            lcg = (lcg * 64'd1103515245 + 64'd12345) & 64'hFFFFFFFF;
            drv(2, lcg >> 8, 1'b1, (i % 7) == 0, "R8 crc8 12-bit words");
        end
        drv(2, 64'hFFF, 1'b0, 1'b0, "R2 crc8 idle");
        drv(2, 64'hABC, 1'b0, 1'b1, "R5 crc8 reload");
        settle();
        chk(c2 == 8'h55, "R5 crc8 reloaded", {56'd0, c2}, 64'h55);

        // R6: output formatting of the 32-bit engine after one word
        drv(0, 64'h00, 1'b1, 1'b1, "R6 format");
        settle();
        chk(c0 == 32'hD202EF8D, "R6 crc32 of zero byte", {32'd0, c0}, 64'hD202EF8D);

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule